// File: doc/BRIEF.md
# Endpoint-0 Status Request Responder

This block answers the standard "get status" control read on endpoint 0 entirely in hardware. It sits behind a packet engine that has already recovered tokens and data packets. The engine hands over each packet as a one-cycle strobe carrying its PID, its endpoint and an error flag. For a setup data packet it also supplies the eight request bytes. In return the block produces a handshake PID, or a DATA1 packet carrying a two-byte status word.

A transfer runs as follows. The SETUP token and its DATA0 payload are acknowledged. The request is checked against the device form and the endpoint form of the status request. The following IN receives the selected word: the device status for the device form, or the halt bit of the addressed endpoint and direction for the endpoint form. The zero-length DATA1 of the status stage is acknowledged. A request that fails the checks receives STALL in both the data stage and the status stage. Corrupted packets get no answer. A fresh SETUP always restarts the sequence. Every answer is registered and appears exactly one cycle after the strobe that caused it.

Top module: `sreq_responder`

## Requirements
- R1: A clean SETUP token to endpoint 0, followed by a clean data packet with PID DATA0 (0x3), yields one handshake with PID ACK (0x2) one cycle after the data strobe.
- R2: A setup data packet with PID DATA1 (0xB), or one flagged with an error, gets no handshake. A following IN token gets no response.
- R3: A token flagged as corrupted produces no output and leaves the transfer where it was, so the next clean token continues it.
- R4: For a device request (byte0 0x80, byte1 0, wValue 0, wIndex 0, wLength 2), the IN (0x9) of the data stage yields a DATA1 packet whose word equals the device status input. Bits [7:0] of the word are the byte sent first.
- R5: For an endpoint request (byte0 0x82, byte1 0, wValue 0, wLength 2, wIndex bits [3:0] endpoint, bit 7 direction with 1 = IN, all other wIndex bits 0), the word is 15 zero bits above the halt flag of that endpoint and direction.
- R6: A request failing any check of R4/R5, including an endpoint number of NUM_EP or more, receives STALL (0xE) on the data-stage IN and again on the status-stage data.
- R7: After the data stage, an OUT (0x1) token and a clean DATA1 packet receive ACK. The block then returns to idle, and a further IN gets no response.
- R8: A status-stage data packet with PID DATA0 receives STALL and ends the transfer.
- R9: A clean SETUP token restarts the sequence from any state, and the previous request is discarded.
- R10: Tokens addressed to a non-zero endpoint, and IN or OUT tokens with no transfer open, produce no output.
- R11: Each response is a single-cycle pulse, and a handshake and a data packet are never emitted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | Token packet strobe |
| tokPid | input | 4 | Token PID |
| tokEp | input | 4 | Token endpoint number |
| tokErr | input | 1 | Token received corrupted |
| datValid | input | 1 | Data packet strobe |
| datPid | input | 4 | Data packet PID |
| datErr | input | 1 | Data packet received with error |
| setupBytes | input | 64 | Request bytes, byte0 in [7:0] |
| devStatus | input | 16 | Device status word |
| epHaltIn | input | NUM_EP | Halt flags, IN direction |
| epHaltOut | input | NUM_EP | Halt flags, OUT direction |
| hsValid | output | 1 | Handshake strobe |
| hsPid | output | 4 | Handshake PID (ACK or STALL) |
| txValid | output | 1 | Data packet strobe |
| txPid | output | 4 | Data packet PID (always DATA1) |
| txData | output | 16 | Status word, [7:0] sent first |

## Verification
The bench builds the block with NUM_EP = 3, a count that is not a power of two. With that value, endpoint 2 is the last one that exists, while 3 fits in the index width but must still be rejected. This reaches the range check at the exact boundary, where a power-of-two count would hide a missing comparison. Random halt patterns on the three endpoints, in both directions, show whether direction and index select the right flag.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  localparam logic [3:0] PID_OUT   = 4'h1;
  localparam logic [3:0] PID_IN    = 4'h9;
  localparam logic [3:0] PID_SETUP = 4'hD;
  localparam logic [3:0] PID_DATA0 = 4'h3;
  localparam logic [3:0] PID_DATA1 = 4'hB;
  localparam logic [3:0] PID_ACK   = 4'h2;
  localparam logic [3:0] PID_STALL = 4'hE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP_DATA, ST_DATA_IN, ST_STATUS_TOK, ST_STATUS_DATA
  } phase_t;

  typedef struct packed {
    logic capture;
    logic sendAck;
    logic sendStall;
    logic sendData;
  } ctrl_t;
endpackage

// File: rtl/sreq_datapath.sv
module sreq_datapath
  import sreq_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [63:0]       setupBytes,
  input  logic [15:0]       devStatus,
  input  logic [NUM_EP-1:0] epHaltIn,
  input  logic [NUM_EP-1:0] epHaltOut,
  output logic              reqOk,
  output logic              hsValid,
  output logic [3:0]        hsPid,
  output logic              txValid,
  output logic [15:0]       txData
);
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;

  logic [7:0]  reqType, reqCode;
  logic [15:0] wValue, wIndex, wLength;
  logic        devForm, epForm, epInRange, okNext;
  logic        isEp, epDirIn;
  logic [EPW-1:0] epNum;
  logic        haltBit;
  logic [15:0] word;

  assign reqType = setupBytes[7:0];
  assign reqCode = setupBytes[15:8];
  assign wValue  = setupBytes[31:16];
  assign wIndex  = setupBytes[47:32];
  assign wLength = setupBytes[63:48];

  always_comb begin
    epInRange = ({28'd0, wIndex[3:0]} < 32'(NUM_EP));
    devForm   = (reqType == 8'h80) && (wIndex == 16'h0000);
    epForm    = (reqType == 8'h82) && (wIndex[15:8] == 8'h00) &&
                (wIndex[6:4] == 3'b000) && epInRange;
    okNext    = (reqCode == 8'h00) && (wValue == 16'h0000) &&
                (wLength == 16'd2) && (devForm || epForm);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOk   <= 1'b0;
      isEp    <= 1'b0;
      epDirIn <= 1'b0;
      epNum   <= '0;
    end else if (ctrl.capture) begin
      reqOk   <= okNext;
      isEp    <= (reqType == 8'h82);
      epDirIn <= wIndex[7];
      epNum   <= wIndex[EPW-1:0];
    end
  end

  always_comb begin
    haltBit = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (EPW'(i) == epNum) haltBit = epDirIn ? epHaltIn[i] : epHaltOut[i];
    end
    word = isEp ? {15'd0, haltBit} : devStatus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsValid <= 1'b0;
      hsPid   <= 4'h0;
      txValid <= 1'b0;
      txData  <= 16'h0000;
    end else begin
      hsValid <= ctrl.sendAck | ctrl.sendStall;
      hsPid   <= ctrl.sendStall ? PID_STALL : (ctrl.sendAck ? PID_ACK : 4'h0);
      txValid <= ctrl.sendData;
      txData  <= ctrl.sendData ? word : 16'h0000;
    end
  end

  // R11: one kind of response per cycle
  a_r11_single_response: assert property (@(posedge clk) disable iff (!rstN)
    !(hsValid && txValid));
  // R6: data only leaves for a request that passed the checks
  a_r6_data_needs_ok: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.sendData |-> reqOk);
  // R1: handshake PID is one of the two the block may emit
  a_r1_hs_code: assert property (@(posedge clk) disable iff (!rstN)
    hsValid |-> (hsPid == PID_ACK || hsPid == PID_STALL));
endmodule

// File: rtl/sreq_control.sv
module sreq_control
  import sreq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokValid,
  input  logic [3:0] tokPid,
  input  logic [3:0] tokEp,
  input  logic       tokErr,
  input  logic       datValid,
  input  logic [3:0] datPid,
  input  logic       datErr,
  input  logic       reqOk,
  output ctrl_t      ctrl
);
  phase_t state, nextState;
  logic   tokGood;

  assign tokGood = tokValid && !tokErr && (tokEp == 4'd0);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    if (tokGood && tokPid == PID_SETUP) begin
      nextState = ST_SETUP_DATA;
    end else begin
      unique case (state)
        ST_SETUP_DATA: begin
          if (datValid) begin
            if (!datErr && datPid == PID_DATA0) begin
              ctrl.capture = 1'b1;
              ctrl.sendAck = 1'b1;
              nextState    = ST_DATA_IN;
            end else begin
              nextState = ST_IDLE;
            end
          end else if (tokGood) begin
            nextState = ST_IDLE;
          end
        end
        ST_DATA_IN: begin
          if (tokGood && tokPid == PID_IN) begin
            ctrl.sendData  = reqOk;
            ctrl.sendStall = !reqOk;
            nextState      = ST_STATUS_TOK;
          end
        end
        ST_STATUS_TOK: begin
          if (tokGood && tokPid == PID_OUT) nextState = ST_STATUS_DATA;
        end
        ST_STATUS_DATA: begin
          if (datValid) begin
            if (datErr) begin
              nextState = ST_STATUS_TOK;
            end else begin
              ctrl.sendAck   = reqOk && (datPid == PID_DATA1);
              ctrl.sendStall = !(reqOk && (datPid == PID_DATA1));
              nextState      = ST_IDLE;
            end
          end else if (tokGood) begin
            nextState = ST_STATUS_TOK;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R3: a corrupted token never moves the sequence
  a_r3_bad_token_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokErr && !datValid) |=> (state == $past(state)));
  // R2: wrong toggle on setup data never opens the data stage
  a_r2_setup_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP_DATA && datValid && datPid == PID_DATA1 && !tokValid)
      |=> (state != ST_DATA_IN));
  // R8: status data with DATA0 closes the transfer
  a_r8_status_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STATUS_DATA && datValid && !datErr && datPid == PID_DATA0 && !tokValid)
      |=> (state == ST_IDLE));
endmodule

// File: rtl/sreq_responder.sv
module sreq_responder
  import sreq_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [3:0]        tokPid,
  input  logic [3:0]        tokEp,
  input  logic              tokErr,
  input  logic              datValid,
  input  logic [3:0]        datPid,
  input  logic              datErr,
  input  logic [63:0]       setupBytes,
  input  logic [15:0]       devStatus,
  input  logic [NUM_EP-1:0] epHaltIn,
  input  logic [NUM_EP-1:0] epHaltOut,
  output logic              hsValid,
  output logic [3:0]        hsPid,
  output logic              txValid,
  output logic [3:0]        txPid,
  output logic [15:0]       txData
);
  ctrl_t ctrl;
  logic  reqOk;

  sreq_control u_ctrl (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokPid(tokPid), .tokEp(tokEp),
    .tokErr(tokErr), .datValid(datValid), .datPid(datPid), .datErr(datErr),
    .reqOk(reqOk), .ctrl(ctrl)
  );

  sreq_datapath #(.NUM_EP(NUM_EP)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .setupBytes(setupBytes),
    .devStatus(devStatus), .epHaltIn(epHaltIn), .epHaltOut(epHaltOut),
    .reqOk(reqOk), .hsValid(hsValid), .hsPid(hsPid), .txValid(txValid),
    .txData(txData)
  );

  assign txPid = PID_DATA1;

  // R4: a data packet only follows a clean IN token
  a_r4_data_after_in: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(tokValid && !tokErr && tokPid == PID_IN && tokEp == 4'd0));
  // R10: nothing answers a token for another endpoint
  a_r10_other_ep: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokEp != 4'd0 && !datValid) |=> !(hsValid || txValid));
endmodule

// File: tb/tb_sreq_responder.sv
module tb_sreq_responder;
  localparam int NEP = 3;
  localparam logic [3:0] P_OUT = 4'h1, P_IN = 4'h9, P_SETUP = 4'hD;
  localparam logic [3:0] P_D0 = 4'h3, P_D1 = 4'hB, P_ACK = 4'h2, P_STALL = 4'hE;
  localparam logic [21:0] NONE = 22'd0;

  logic clk = 0, rstN = 0;
  logic tokValid = 0, tokErr = 0, datValid = 0, datErr = 0;
  logic [3:0] tokPid = 0, tokEp = 0, datPid = 0;
  logic [63:0] setupBytes = 0;
  logic [15:0] devStatus = 0;
  logic [NEP-1:0] epHaltIn = 0, epHaltOut = 0;
  logic hsValid, txValid;
  logic [3:0] hsPid, txPid;
  logic [15:0] txData;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sreq_responder #(.NUM_EP(NEP)) dut (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokPid(tokPid), .tokEp(tokEp),
    .tokErr(tokErr), .datValid(datValid), .datPid(datPid), .datErr(datErr),
    .setupBytes(setupBytes), .devStatus(devStatus), .epHaltIn(epHaltIn),
    .epHaltOut(epHaltOut), .hsValid(hsValid), .hsPid(hsPid), .txValid(txValid),
    .txPid(txPid), .txData(txData)
  );

  function automatic logic [21:0] hs(input logic [3:0] p);
    return {1'b1, p, 17'd0};
  endfunction
  function automatic logic [21:0] tx(input logic [15:0] w);
    return {5'd0, 1'b1, w};
  endfunction
  function automatic logic [21:0] observe();
    logic [15:0] w;
    w = txValid ? txData : 16'h0;
    if (txValid && txPid != P_D1) w = ~txData;
    return {hsValid, hsValid ? hsPid : 4'h0, txValid, w};
  endfunction
  function automatic logic [63:0] mkReq(input logic [7:0] t, input logic [7:0] c,
      input logic [15:0] v, input logic [15:0] idx, input logic [15:0] len);
    return {len, idx, v, c, t};
  endfunction
  function automatic bit expOk(input logic [63:0] b);
    bit ok;
    ok = (b[15:8] == 0) && (b[31:16] == 0) && (b[63:48] == 2);
    if (b[7:0] == 8'h80) return ok && (b[47:32] == 0);
    if (b[7:0] == 8'h82)
      return ok && (b[47:40] == 0) && (b[38:36] == 0) && (int'(b[35:32]) < NEP);
    return 0;
  endfunction
  function automatic logic [15:0] expWord(input logic [63:0] b);
    if (b[7:0] == 8'h80) return devStatus;
    return {15'd0, b[39] ? epHaltIn[b[33:32]] : epHaltOut[b[33:32]]};
  endfunction

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask
  task automatic tok(input logic [3:0] p, input logic [3:0] ep, input bit e,
                     output logic [21:0] obs);
    tokValid = 1; tokPid = p; tokEp = ep; tokErr = e;
    @(negedge clk);
    tokValid = 0; tokErr = 0;
    obs = observe();
  endtask
  task automatic dat(input logic [3:0] p, input bit e, output logic [21:0] obs);
    datValid = 1; datPid = p; datErr = e;
    @(negedge clk);
    datValid = 0; datErr = 0;
    obs = observe();
  endtask
  // Full transfer with a clean setup; checks each stage's answer
  task automatic transfer(input logic [63:0] b, input logic [3:0] stPid, input string req);
    logic [21:0] o;
    bit ok;
    ok = expOk(b);
    setupBytes = b;
    tok(P_SETUP, 0, 0, o); check({req, "/R1 token"}, o, NONE);
    dat(P_D0, 0, o);       check({req, "/R1 setup ack"}, o, hs(P_ACK));
    tok(P_IN, 0, 0, o);    check({req, "/R4 R5 R6 data"}, o, ok ? tx(expWord(b)) : hs(P_STALL));
    tok(P_OUT, 0, 0, o);   check({req, "/R7 out token"}, o, NONE);
    dat(stPid, 0, o);
    check({req, "/R7 R8 status"}, o, (ok && stPid == P_D1) ? hs(P_ACK) : hs(P_STALL));
  endtask

  initial begin
    logic [21:0] o;
    void'($urandom(32'd1234));
    devStatus = 16'hA503; epHaltIn = 3'b101; epHaltOut = 3'b010;
    repeat (3) @(negedge clk);
    o = observe(); check("reset R11", o, NONE);
    rstN = 1;
    @(negedge clk);
    o = observe(); check("idle after reset R10", o, NONE);

    transfer(mkReq(8'h80, 0, 0, 0, 2), P_D1, "device R4");
    tok(P_IN, 0, 0, o); check("idle after status R7", o, NONE);
    @(negedge clk); o = observe(); check("single pulse R11", o, NONE);
    transfer(mkReq(8'h82, 0, 0, 16'h0082, 2), P_D1, "ep2 in R5");
    transfer(mkReq(8'h82, 0, 0, 16'h0001, 2), P_D1, "ep1 out R5");
    transfer(mkReq(8'h82, 0, 0, 16'h0003, 2), P_D1, "ep3 missing R6");
    transfer(mkReq(8'h82, 0, 0, 16'h0013, 2), P_D1, "wIndex junk R6");
    transfer(mkReq(8'h80, 0, 0, 0, 1), P_D1, "length R6");
    transfer(mkReq(8'h80, 0, 0, 0, 2), P_D0, "status toggle R8");

    // R2: setup data with DATA1, then with an error
    setupBytes = mkReq(8'h80, 0, 0, 0, 2);
    tok(P_SETUP, 0, 0, o); dat(P_D1, 0, o); check("setup DATA1 R2", o, NONE);
    tok(P_IN, 0, 0, o); check("IN after bad setup R2", o, NONE);
    tok(P_SETUP, 0, 0, o); dat(P_D0, 1, o); check("setup data err R2", o, NONE);
    tok(P_IN, 0, 0, o); check("IN after err setup R2", o, NONE);

    // R3: corrupted tokens mid-transfer
    tok(P_SETUP, 0, 1, o); check("bad SETUP token R3", o, NONE);
    tok(P_SETUP, 0, 0, o); dat(P_D0, 0, o); check("setup ack R3", o, hs(P_ACK));
    tok(P_IN, 0, 1, o); check("bad IN token R3", o, NONE);
    tok(P_IN, 0, 0, o); check("IN after bad token R3", o, tx(16'hA503));
    tok(P_OUT, 0, 0, o); dat(P_D1, 0, o); check("status R3", o, hs(P_ACK));

    // R9: new setup aborts a transfer
    setupBytes = mkReq(8'h80, 0, 0, 0, 2);
    tok(P_SETUP, 0, 0, o); dat(P_D0, 0, o);
    setupBytes = mkReq(8'h82, 0, 0, 16'h0005, 2);
    tok(P_SETUP, 0, 0, o); dat(P_D0, 0, o); check("re-setup ack R9", o, hs(P_ACK));
    tok(P_IN, 0, 0, o); check("re-setup stall R9", o, hs(P_STALL));
    tok(P_OUT, 0, 0, o); dat(P_D1, 0, o); check("re-setup status R9", o, hs(P_STALL));

    // R10: other endpoint
    setupBytes = mkReq(8'h80, 0, 0, 0, 2);
    tok(P_SETUP, 0, 0, o); dat(P_D0, 0, o);
    tok(P_IN, 4'd1, 0, o); check("IN to ep1 R10", o, NONE);
    tok(P_IN, 0, 0, o); check("IN ep0 after ep1 R10", o, tx(16'hA503));
    tok(P_OUT, 0, 0, o); dat(P_D1, 0, o);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] b;
      int kind;
      devStatus = 16'($urandom); epHaltIn = NEP'($urandom); epHaltOut = NEP'($urandom);
      kind = $urandom_range(0, 3);
      if (kind == 0) b = mkReq(8'h80, 0, 0, 0, 2);
      else if (kind == 1) b = mkReq(8'h82, 0, 0, {8'h0, 1'($urandom), 3'd0, 4'($urandom_range(0, 4))}, 2);
      else if (kind == 2) b = mkReq(($urandom % 2) ? 8'h80 : 8'h82, 8'($urandom % 2), 16'($urandom % 2),
                                   16'($urandom % 3), 16'($urandom_range(1, 3)));
      else b = {$urandom, $urandom};
      if ($urandom % 4 == 0) begin
        tok(4'($urandom), 0, 1, o); check("random bad token R3", o, NONE);
      end
      transfer(b, ($urandom % 5 == 0) ? P_D0 : P_D1, "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule